// File: doc/BRIEF.md
# SMBus Reserved-Window Write Guard

This block sits between the host command registers of an SMBus controller and its bus-protocol engine. It decides whether a requested transaction may go to the bus. Each request arrives as a start strobe together with the transmit slave address byte and a transaction-type code. The guard classifies the request as a read or a write, checks the 7-bit target address against a protected window (0x50 to 0x57 by default), and either forwards the start or refuses it.

The read/write decision comes from the transaction type rather than from the address direction bit alone. An I2C block read, which is issued with the direction bit cleared, is therefore treated as a read and reaches the protected window. A Send Byte with the direction bit cleared is a write and is still refused. Protection is armed by a configuration bit that software can write only once after each reset.

A refused request never reaches the engine. Instead the guard returns a one-cycle completion pulse and sets a sticky error flag, which software clears with a write-1-to-clear strobe.

Top module: `spd_wp_gate`

## Requirements
- R1: After reset, fwd_start_o, done_o and blk_err_o are 0 and protection is disabled.
- R2: The first cfg_we_i pulse after reset loads cfg_wp_i into the protect-enable state, whether the value is 0 or 1. Any later cfg_we_i pulse is ignored until the next reset.
- R3: While protect-enable is 0, every request is forwarded, whatever its address or type.
- R4: While protect-enable is 1, a write whose 7-bit address (slv_addr_i[7:1]) lies in 0x50..0x57 is refused.
- R5: Type code 5 (I2C block read) is always classified as a read, whatever the value of slv_addr_i[0].
- R6: For type codes 0 (Quick), 1 (Send/Receive Byte), 2 (Byte Data), 3 (Word Data) and 4 (Block), slv_addr_i[0]=1 means read and 0 means write. Reads to the window are forwarded.
- R7: A request whose 7-bit address is outside 0x50..0x57 is forwarded, whatever its type or the protect state.
- R8: A request is sampled on the clock edge where start_i is 1. Its result appears on the outputs in the following cycle, and fwd_start_o is a one-cycle pulse.
- R9: For a refused request, fwd_start_o stays 0, done_o pulses for one cycle, and blk_err_o is set in that same cycle.
- R10: blk_err_o stays set until err_clr_i is sampled high. If a clear and a refusal are sampled on the same edge, the flag stays set.
- R11: A request that arrives while blk_err_o is set is evaluated normally. If it is allowed it is forwarded, and the flag is left set.
- R12: Type codes 6..15 are classified as writes.
- R13: The protect state used for a request is the one in effect before the edge that samples it. A configuration write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe for the protect-enable bit |
| cfg_wp_i | input | 1 | Protect-enable value to write |
| slv_addr_i | input | 8 | Transmit slave address byte: address in [7:1], direction in [0] |
| xact_type_i | input | 4 | Transaction-type code |
| start_i | input | 1 | Request strobe |
| err_clr_i | input | 1 | Write-1-to-clear strobe for the error flag |
| fwd_start_o | output | 1 | Start pulse forwarded to the protocol engine |
| blk_err_o | output | 1 | Sticky refused-transaction flag |
| done_o | output | 1 | Completion pulse for a refused request |

## Verification
A wrong protect-enable state or a wrong lock state shows up at the ports on the first request to the window after the fault. The request is either forwarded when it should be refused, or refused when it should be forwarded. A misclassified type or direction has the same effect, one cycle after the strobe. A corrupted error flag is visible at once on blk_err_o and persists until a clear strobe or a reset.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned TYPE_W = 4;

  typedef enum logic [TYPE_W-1:0] {
    XT_QUICK     = 4'd0,
    XT_BYTE      = 4'd1,
    XT_BYTE_DATA = 4'd2,
    XT_WORD_DATA = 4'd3,
    XT_BLOCK     = 4'd4,
    XT_I2C_BLKRD = 4'd5
  } xact_e;

  typedef struct packed {
    logic is_write;
    logic in_win;
  } req_class_t;
endpackage

// File: rtl/spd_wp_lock.sv
module spd_wp_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic en_o,
  output logic locked_o
);
  logic en_q, locked_q;

  // one write per reset, any value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      locked_q <= 1'b0;
    end else if (we_i && !locked_q) begin
      en_q     <= d_i;
      locked_q <= 1'b1;
    end
  end

  assign en_o     = en_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/spd_wp_classify.sv
module spd_wp_classify
  import spd_wp_pkg::*;
#(
  parameter int unsigned       WIN_LOG2  = 3,
  parameter logic [ADDR_W-2:0] WIN_BASE  = 7'h50,
  parameter int unsigned       DIR_TYPES = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPE_W-1:0] type_i,
  output req_class_t        cls_o
);
  localparam int unsigned A7W = ADDR_W - 1;

  logic [A7W-1:0] addr7;
  logic           in_win;
  assign addr7 = addr_i[ADDR_W-1:1];

  generate
    if (WIN_LOG2 == 0) begin : g_exact
      assign in_win = (addr7 == WIN_BASE);
    end else begin : g_prefix
      assign in_win = (addr7[A7W-1:WIN_LOG2] == WIN_BASE[A7W-1:WIN_LOG2]);
    end
  endgenerate

  always_comb begin
    cls_o.in_win = in_win;
    if (type_i == XT_I2C_BLKRD)
      cls_o.is_write = 1'b0;           // read despite cleared direction bit
    else if (32'(type_i) < DIR_TYPES)
      cls_o.is_write = ~addr_i[0];
    else
      cls_o.is_write = 1'b1;           // unknown codes treated as writes
  end
endmodule

// File: rtl/spd_wp_decide.sv
module spd_wp_decide
  import spd_wp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wp_en_i,
  input  req_class_t cls_i,
  input  logic       err_clr_i,
  output logic       fwd_start_o,
  output logic       done_o,
  output logic       blk_err_o
);
  logic refuse;
  logic fwd_q, done_q, err_q;

  assign refuse = wp_en_i && cls_i.is_write && cls_i.in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      fwd_q  <= start_i && !refuse;
      done_q <= start_i && refuse;
      if (start_i && refuse) err_q <= 1'b1;   // set wins over clear
      else if (err_clr_i)    err_q <= 1'b0;
    end
  end

  assign fwd_start_o = fwd_q;
  assign done_o      = done_q;
  assign blk_err_o   = err_q;
endmodule

// File: rtl/spd_wp_gate.sv
module spd_wp_gate
  import spd_wp_pkg::*;
#(
  parameter int unsigned       WIN_LOG2  = 3,
  parameter logic [ADDR_W-2:0] WIN_BASE  = 7'h50,
  parameter int unsigned       DIR_TYPES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_wp_i,
  input  logic [ADDR_W-1:0] slv_addr_i,
  input  logic [TYPE_W-1:0] xact_type_i,
  input  logic              start_i,
  input  logic              err_clr_i,
  output logic              fwd_start_o,
  output logic              blk_err_o,
  output logic              done_o
);
  logic       wp_en, wp_locked;
  req_class_t cls;

  spd_wp_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .d_i      (cfg_wp_i),
    .en_o     (wp_en),
    .locked_o (wp_locked)
  );

  spd_wp_classify #(
    .WIN_LOG2  (WIN_LOG2),
    .WIN_BASE  (WIN_BASE),
    .DIR_TYPES (DIR_TYPES)
  ) u_cls (
    .addr_i (slv_addr_i),
    .type_i (xact_type_i),
    .cls_o  (cls)
  );

  spd_wp_decide u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .wp_en_i     (wp_en),
    .cls_i       (cls),
    .err_clr_i   (err_clr_i),
    .fwd_start_o (fwd_start_o),
    .done_o      (done_o),
    .blk_err_o   (blk_err_o)
  );
endmodule

// File: rtl/spd_wp_gate_chk.sv
module spd_wp_gate_chk
  import spd_wp_pkg::*;
#(
  parameter int unsigned       WIN_LOG2 = 3,
  parameter logic [ADDR_W-2:0] WIN_BASE = 7'h50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] slv_addr_i,
  input logic [TYPE_W-1:0] xact_type_i,
  input logic              start_i,
  input logic              err_clr_i,
  input logic              fwd_start_o,
  input logic              blk_err_o,
  input logic              done_o,
  input logic              wp_en,
  input logic              wp_locked
);
  logic seen_q;
  logic chk_in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign chk_in_win = ((slv_addr_i >> (WIN_LOG2 + 1)) == ADDR_W'(WIN_BASE >> WIN_LOG2));

  assert_fwd_from_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && fwd_start_o |-> $past(start_i));
  assert_fwd_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && fwd_start_o && !start_i |=> !fwd_start_o);
  assert_fwd_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_start_o && done_o));
  assert_done_sets_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> blk_err_o);
  assert_err_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $rose(blk_err_o) |-> done_o);
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(blk_err_o) && !$past(err_clr_i) |-> blk_err_o);
  assert_write_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(wp_locked) |-> $stable(wp_en));
  assert_off_forwards_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(start_i) && !$past(wp_en) |-> fwd_start_o);
  assert_blkrd_forwards_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(start_i) && ($past(xact_type_i) == 4'd5) |-> fwd_start_o);
  assert_outside_forwards_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(start_i) && !$past(chk_in_win) |-> fwd_start_o);
endmodule

bind spd_wp_gate spd_wp_gate_chk #(
  .WIN_LOG2 (WIN_LOG2),
  .WIN_BASE (WIN_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slv_addr_i  (slv_addr_i),
  .xact_type_i (xact_type_i),
  .start_i     (start_i),
  .err_clr_i   (err_clr_i),
  .fwd_start_o (fwd_start_o),
  .blk_err_o   (blk_err_o),
  .done_o      (done_o),
  .wp_en       (wp_en),
  .wp_locked   (wp_locked)
);

// File: tb/sim_spd_wp_gate.sv
`timescale 1ns/1ps
module sim_spd_wp_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_wp_i = 1'b0;
  logic [7:0] slv_addr_i = '0;
  logic [3:0] xact_type_i = '0;
  logic       start_i = 1'b0, err_clr_i = 1'b0;
  logic       fwd_start_o, blk_err_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spd_wp_gate u0 (.*);

  // {addr, type, expect_forward}, protection on
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    {8'hA0, 4'd1,  1'b0},  // R4 send byte to 0x50
    {8'hA1, 4'd1,  1'b1},  // R6 receive byte
    {8'hA0, 4'd5,  1'b1},  // R5 block read, bit0=0
    {8'hA1, 4'd5,  1'b1},  // R5
    {8'hAE, 4'd2,  1'b0},  // R4 write byte data to 0x57
    {8'hAF, 4'd3,  1'b1},  // R6 read word
    {8'hA0, 4'd0,  1'b0},  // R6 quick write
    {8'hA1, 4'd0,  1'b1},  // R6 quick read
    {8'hA5, 4'd4,  1'b1},  // R6 block read
    {8'hA4, 4'd4,  1'b0},  // R4 block write
    {8'h9E, 4'd1,  1'b1},  // R7 0x4F write
    {8'hB0, 4'd2,  1'b1},  // R7 0x58 write
    {8'hA2, 4'd9,  1'b0},  // R12
    {8'hA3, 4'd15, 1'b0},  // R12
    {8'h30, 4'd6,  1'b1}   // R7
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cfg_write(input logic v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wp_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // drive one request; returns sampled outputs one cycle after the strobe
  task automatic req(input logic [7:0] a, input logic [3:0] t,
                     output logic f, output logic d, output logic e);
    @(negedge clk_i);
    slv_addr_i = a; xact_type_i = t; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    f = fwd_start_o; d = done_o; e = blk_err_o;
  endtask

  task automatic clr();
    @(negedge clk_i);
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic f, d, e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 fwd", fwd_start_o, 1'b0);
    check("R1 done", done_o, 1'b0);
    check("R1 err", blk_err_o, 1'b0);
    req(8'hA0, 4'd1, f, d, e);
    check("R1 protection off after reset", f, 1'b1);

    // table under protection
    do_reset();
    cfg_write(1'b1);
    for (int i = 0; i < NV; i++) begin
      req(VEC[i][12:5], VEC[i][4:1], f, d, e);
      check($sformatf("R4/R5/R6/R7/R12 vec%0d fwd", i), f, VEC[i][0]);
      check($sformatf("R9 vec%0d done", i), d, !VEC[i][0]);
      check($sformatf("R9 vec%0d err", i), e, !VEC[i][0]);
      @(negedge clk_i);
      check($sformatf("R8 vec%0d fwd pulse", i), fwd_start_o, 1'b0);
      check($sformatf("R9 vec%0d done pulse", i), done_o, 1'b0);
      clr();
      check($sformatf("R10 vec%0d cleared", i), blk_err_o, 1'b0);
    end

    // R3: protection off forwards window writes
    do_reset();
    cfg_write(1'b0);
    req(8'hA0, 4'd1, f, d, e);
    check("R3 fwd", f, 1'b1);
    check("R3 no done", d, 1'b0);
    // R2: later write of 1 ignored
    cfg_write(1'b1);
    req(8'hA0, 4'd2, f, d, e);
    check("R2 second write ignored", f, 1'b1);

    // R2: write 1 then 0 stays protected
    do_reset();
    cfg_write(1'b1);
    cfg_write(1'b0);
    req(8'hA0, 4'd1, f, d, e);
    check("R2 protect kept", f, 1'b0);
    check("R2 err", e, 1'b1);

    // R11: allowed request while error set
    req(8'hA1, 4'd1, f, d, e);
    check("R11 fwd", f, 1'b1);
    check("R11 err kept", e, 1'b1);

    // R10: clear and refusal on the same edge
    @(negedge clk_i);
    slv_addr_i = 8'hA0; xact_type_i = 4'd1; start_i = 1'b1; err_clr_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; err_clr_i = 1'b0;
    check("R10 set wins", blk_err_o, 1'b1);
    check("R10 done", done_o, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R10 sticky", blk_err_o, 1'b1);
    clr();
    check("R10 cleared", blk_err_o, 1'b0);

    // R13: config write on the strobe edge applies to later requests
    do_reset();
    @(negedge clk_i);
    slv_addr_i = 8'hA0; xact_type_i = 4'd1; start_i = 1'b1;
    cfg_we_i = 1'b1; cfg_wp_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; cfg_we_i = 1'b0;
    check("R13 same edge forwarded", fwd_start_o, 1'b1);
    req(8'hA0, 4'd1, f, d, e);
    check("R13 later refused", f, 1'b0);
    check("R13 later done", d, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule